// File: doc/BRIEF.md
# Low-Power Receive Timeout Recovery Sequencer

This block guards the link while it sits in low-power receive direction after a bus turnaround. Software arms it by writing 1 to an arm bit. Once the link turns to receive, a programmable down-counter runs. The count is abandoned if the link turns back to transmit in time, and the block drops back to idle if software withdraws the arm bit. If the peripheral never returns the bus before the count runs out, the block walks through a fixed recovery sequence:

1. A one-cycle timeout interrupt is raised, and the arm bit is cleared by hardware.
2. The lanes are held in the LP-11 stop state for a programmable minimum time.
3. A two-cycle internal logic reset is issued. It spares the registers and the transmit FIFO, so the FIFO is not flushed here.
4. A one-cycle strobe clears the interface-enable bit.

Software waits until both the stop-state control and the interface enable read back as 0 before it starts its own recovery. Software writes to the arm bit are locked out for the whole of the sequence. The current sequencer state is exposed as a 3-bit code, so each recovery step can be observed in order.

Top module: `lprx_rx_watchdog`

## Requirements
- R1: While reset is held and in the first cycle after it, `fsm_state` is 0 (idle), and `arm_rb`, `to_irq`, `force_stop`, `logic_rst` and `if_en_clr` are all 0.
- R2: A write (`sw_we`=1) sets `arm_rb` to `sw_wdata` one cycle later. When `arm_rb` is 1 in idle, the next state is 1 (armed). The state codes are 0 idle, 1 armed, 2 timing, 3 trip, 4 stop, 5 scrub and 6 drop.
- R3: In the armed state the block waits while `link_rx` is 0. The cycle after `link_rx` is seen at 1, the state is 2 (timing).
- R4: With `link_rx` held at 1, the block stays in timing for exactly max(`limit_rx`,1) cycles, and then enters trip. A limit of 0 behaves as 1.
- R5: If `link_rx` is 0 in a timing cycle that is not the final one, the block returns to armed, and the next timing run starts again from the full count. If `link_rx` falls in the final timing cycle, the timeout still occurs.
- R6: If `arm_rb` is 0 while the state is armed or timing, the next state is idle, and no interrupt is raised.
- R7: `to_irq` is high for exactly one cycle, in the trip state (3), and `arm_rb` is already 0 in that cycle.
- R8: Right after the trip cycle, `force_stop` is high for exactly max(`limit_stop`,1) cycles, in state 4.
- R9: As soon as `force_stop` falls, `logic_rst` is high for exactly 2 cycles, in state 5.
- R10: Right after `logic_rst` falls, `if_en_clr` is high for one cycle, in state 6, and the state then returns to idle. At most one of `to_irq`, `force_stop`, `logic_rst` and `if_en_clr` is high in any cycle.
- R11: Software writes made in states 3 to 6 are ignored. `arm_rb` stays 0 through the sequence and after it, and the block stays in idle afterwards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sw_we | input | 1 | Software write strobe for the arm bit |
| sw_wdata | input | 1 | Value written to the arm bit |
| limit_rx | input | CNT_W | Receive timeout length in cycles (0 means 1) |
| limit_stop | input | CNT_W | Minimum stop-state length in cycles (0 means 1) |
| link_rx | input | 1 | 1 while the link is in receive direction |
| arm_rb | output | 1 | Arm bit readback |
| to_irq | output | 1 | Timeout interrupt pulse |
| force_stop | output | 1 | Force the lanes into LP-11 stop state |
| logic_rst | output | 1 | Internal logic reset (registers and TX FIFO kept) |
| if_en_clr | output | 1 | Clear strobe for the interface-enable bit |
| fsm_state | output | 3 | Current sequencer state code |

## Verification
Two events can land in the same cycle, and the bench provokes both.

The first is the link turning back to transmit in the very cycle the receive count completes. The bench drops `link_rx` exactly on the last timing cycle. It then expects the trip state in the following cycle, not a return to armed.

The second is a software write to the arm bit arriving while hardware holds it cleared during recovery. The bench writes 1 in every recovery cycle. It expects `arm_rb` to stay 0 throughout and the block to remain idle after the drop step.

Every cycle's state code and outputs are compared against a queue of expected values that the bench builds.

// File: rtl/lprx_pkg.sv
package lprx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_ARMED  = 3'd1,
        ST_TIMING = 3'd2,
        ST_TRIP   = 3'd3,
        ST_STOP   = 3'd4,
        ST_SCRUB  = 3'd5,
        ST_DROP   = 3'd6
    } lprx_state_e;

    typedef struct packed {
        logic irq;
        logic force_stop;
        logic scrub;
        logic drop_if;
    } lprx_outs_t;

    // Cycles the internal logic reset stays high.
    localparam int unsigned SCRUB_CYCLES = 2;

    // Number of independent down-counters (receive timeout, stop state).
    localparam int unsigned NUM_TIMERS = 2;
    localparam int unsigned TMR_RX     = 0;
    localparam int unsigned TMR_STOP   = 1;

    function automatic logic in_recovery(input lprx_state_e s);
        return (s == ST_TRIP) || (s == ST_STOP) || (s == ST_SCRUB) || (s == ST_DROP);
    endfunction

    function automatic lprx_outs_t decode_outs(input lprx_state_e s);
        lprx_outs_t o;
        o.irq        = (s == ST_TRIP);
        o.force_stop = (s == ST_STOP);
        o.scrub      = (s == ST_SCRUB);
        o.drop_if    = (s == ST_DROP);
        return o;
    endfunction

endpackage

// File: rtl/lprx_arm_reg.sv
module lprx_arm_reg (
    input  logic clk,
    input  logic rst,
    input  logic sw_we,
    input  logic sw_wdata,
    input  logic hw_clr,
    input  logic lock,
    output logic arm_q
);

    // Hardware clear wins; software writes are dropped while locked.
    always_ff @(posedge clk) begin
        if (rst) begin
            arm_q <= 1'b0;
        end else if (hw_clr) begin
            arm_q <= 1'b0;
        end else if (sw_we && !lock) begin
            arm_q <= sw_wdata;
        end
    end

endmodule

// File: rtl/lprx_down_ctr.sv
module lprx_down_ctr #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic         last
);

    localparam logic [W-1:0] ONE = W'(1);

    logic [W-1:0] cnt_q;
    logic [W-1:0] start_val;

    // A programmed zero is treated as a single cycle.
    assign start_val = (load_val == '0) ? ONE : load_val;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= start_val;
        end else if (dec && (cnt_q > ONE)) begin
            cnt_q <= cnt_q - ONE;
        end
    end

    assign last = (cnt_q == ONE);

endmodule

// File: rtl/lprx_seq_fsm.sv
module lprx_seq_fsm
    import lprx_pkg::*;
#(
    parameter int unsigned SCRUB_N = SCRUB_CYCLES
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        arm,
    input  logic        link_rx,
    input  logic        rx_last,
    input  logic        stop_last,
    output lprx_state_e state,
    output logic        rx_load,
    output logic        rx_dec,
    output logic        stop_load,
    output logic        stop_dec,
    output logic        hw_clr
);

    localparam int unsigned SW = (SCRUB_N > 1) ? $clog2(SCRUB_N) : 1;
    localparam logic [SW-1:0] SCRUB_END = SW'(SCRUB_N - 1);

    lprx_state_e state_q, state_d;
    logic [SW-1:0] scrub_q, scrub_d;

    always_comb begin
        state_d   = state_q;
        scrub_d   = scrub_q;
        rx_load   = 1'b0;
        rx_dec    = 1'b0;
        stop_load = 1'b0;
        stop_dec  = 1'b0;
        hw_clr    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                rx_load = 1'b1;
                if (arm) state_d = ST_ARMED;
            end
            ST_ARMED: begin
                rx_load = 1'b1;
                if (!arm)        state_d = ST_IDLE;
                else if (link_rx) state_d = ST_TIMING;
            end
            ST_TIMING: begin
                // Priority: disarm, then completion, then direction change.
                if (!arm) begin
                    state_d = ST_IDLE;
                end else if (rx_last) begin
                    state_d = ST_TRIP;
                    hw_clr  = 1'b1;
                end else if (!link_rx) begin
                    state_d = ST_ARMED;
                end else begin
                    rx_dec = 1'b1;
                end
            end
            ST_TRIP: begin
                stop_load = 1'b1;
                state_d   = ST_STOP;
            end
            ST_STOP: begin
                scrub_d = '0;
                if (stop_last) state_d = ST_SCRUB;
                else           stop_dec = 1'b1;
            end
            ST_SCRUB: begin
                if (scrub_q == SCRUB_END) state_d = ST_DROP;
                else                      scrub_d = scrub_q + SW'(1);
            end
            ST_DROP: begin
                state_d = ST_IDLE;
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            scrub_q <= '0;
        end else begin
            state_q <= state_d;
            scrub_q <= scrub_d;
        end
    end

    assign state = state_q;

endmodule

// File: rtl/lprx_rx_watchdog.sv
module lprx_rx_watchdog
    import lprx_pkg::*;
#(
    parameter int unsigned CNT_W   = 16,
    parameter int unsigned SCRUB_N = SCRUB_CYCLES
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sw_we,
    input  logic             sw_wdata,
    input  logic [CNT_W-1:0] limit_rx,
    input  logic [CNT_W-1:0] limit_stop,
    input  logic             link_rx,
    output logic             arm_rb,
    output logic             to_irq,
    output logic             force_stop,
    output logic             logic_rst,
    output logic             if_en_clr,
    output logic [2:0]       fsm_state
);

    lprx_state_e state;
    lprx_outs_t  outs;
    logic        hw_clr;
    logic        arm_q;

    logic             tmr_load [NUM_TIMERS];
    logic             tmr_dec  [NUM_TIMERS];
    logic             tmr_last [NUM_TIMERS];
    logic [CNT_W-1:0] tmr_val  [NUM_TIMERS];

    assign tmr_val[TMR_RX]   = limit_rx;
    assign tmr_val[TMR_STOP] = limit_stop;

    lprx_arm_reg u_arm (
        .clk      (clk),
        .rst      (rst),
        .sw_we    (sw_we),
        .sw_wdata (sw_wdata),
        .hw_clr   (hw_clr),
        .lock     (in_recovery(state)),
        .arm_q    (arm_q)
    );

    for (genvar g = 0; g < NUM_TIMERS; g++) begin : g_tmr
        lprx_down_ctr #(.W(CNT_W)) u_ctr (
            .clk      (clk),
            .rst      (rst),
            .load     (tmr_load[g]),
            .load_val (tmr_val[g]),
            .dec      (tmr_dec[g]),
            .last     (tmr_last[g])
        );
    end

    lprx_seq_fsm #(.SCRUB_N(SCRUB_N)) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .arm       (arm_q),
        .link_rx   (link_rx),
        .rx_last   (tmr_last[TMR_RX]),
        .stop_last (tmr_last[TMR_STOP]),
        .state     (state),
        .rx_load   (tmr_load[TMR_RX]),
        .rx_dec    (tmr_dec[TMR_RX]),
        .stop_load (tmr_load[TMR_STOP]),
        .stop_dec  (tmr_dec[TMR_STOP]),
        .hw_clr    (hw_clr)
    );

    assign outs       = decode_outs(state);
    assign arm_rb     = arm_q;
    assign to_irq     = outs.irq;
    assign force_stop = outs.force_stop;
    assign logic_rst  = outs.scrub;
    assign if_en_clr  = outs.drop_if;
    assign fsm_state  = state;

endmodule

// File: rtl/lprx_rx_watchdog_chk.sv
module lprx_rx_watchdog_chk (
    input logic       clk,
    input logic       rst,
    input logic       arm_rb,
    input logic       to_irq,
    input logic       force_stop,
    input logic       logic_rst,
    input logic       if_en_clr,
    input logic [2:0] fsm_state
);

    a_r6_disarm_to_idle: assert property (@(posedge clk) disable iff (rst)
        (((fsm_state == 3'd1) || (fsm_state == 3'd2)) && !arm_rb) |=> (fsm_state == 3'd0));

    a_r7_irq_single: assert property (@(posedge clk) disable iff (rst)
        to_irq |=> !to_irq);

    a_r7_arm_cleared: assert property (@(posedge clk) disable iff (rst)
        to_irq |-> !arm_rb);

    a_r8_stop_follows_irq: assert property (@(posedge clk) disable iff (rst)
        to_irq |=> force_stop);

    a_r9_scrub_follows_stop: assert property (@(posedge clk) disable iff (rst)
        $fell(force_stop) |-> logic_rst);

    a_r9_scrub_min: assert property (@(posedge clk) disable iff (rst)
        $rose(logic_rst) |=> logic_rst);

    a_r9_scrub_max: assert property (@(posedge clk) disable iff (rst)
        (logic_rst && $past(logic_rst)) |=> !logic_rst);

    a_r10_clear_follows_scrub: assert property (@(posedge clk) disable iff (rst)
        $fell(logic_rst) |-> if_en_clr);

    a_r10_idle_after_clear: assert property (@(posedge clk) disable iff (rst)
        if_en_clr |=> ((fsm_state == 3'd0) && !if_en_clr));

    a_r10_exclusive: assert property (@(posedge clk) disable iff (rst)
        $onehot0({to_irq, force_stop, logic_rst, if_en_clr}));

    a_r11_arm_locked: assert property (@(posedge clk) disable iff (rst)
        (fsm_state >= 3'd3) |=> !arm_rb);

endmodule

bind lprx_rx_watchdog lprx_rx_watchdog_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .arm_rb     (arm_rb),
    .to_irq     (to_irq),
    .force_stop (force_stop),
    .logic_rst  (logic_rst),
    .if_en_clr  (if_en_clr),
    .fsm_state  (fsm_state)
);

// File: tb/lprx_rx_watchdog_test.sv
module lprx_rx_watchdog_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sw_we = 1'b0;
    logic        sw_wdata = 1'b0;
    logic [15:0] limit_rx = 16'd0;
    logic [15:0] limit_stop = 16'd0;
    logic        link_rx = 1'b0;
    logic        arm_rb, to_irq, force_stop, logic_rst, if_en_clr;
    logic [2:0]  fsm_state;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    typedef struct {
        logic [7:0] v;
        string      tag;
    } item_t;
    item_t exp_q[$];

    always #2 clk = ~clk;

    lprx_rx_watchdog uut (
        .clk        (clk),
        .rst        (rst),
        .sw_we      (sw_we),
        .sw_wdata   (sw_wdata),
        .limit_rx   (limit_rx),
        .limit_stop (limit_stop),
        .link_rx    (link_rx),
        .arm_rb     (arm_rb),
        .to_irq     (to_irq),
        .force_stop (force_stop),
        .logic_rst  (logic_rst),
        .if_en_clr  (if_en_clr),
        .fsm_state  (fsm_state)
    );

    // Expected vector: {state, arm, irq(st3), stop(st4), scrub(st5), clear(st6)}
    function automatic logic [7:0] ev(input logic [2:0] st, input logic arm);
        return {st, arm, st == 3'd3, st == 3'd4, st == 3'd5, st == 3'd6};
    endfunction

    // Monitor: pop one expected item per cycle, compare mid-cycle.
    always @(negedge clk) begin
        item_t it;
        logic [7:0] act;
        if (exp_q.size() > 0) begin
            it  = exp_q.pop_front();
            act = {fsm_state, arm_rb, to_irq, force_stop, logic_rst, if_en_clr};
            checks++;
            if (act !== it.v) begin
                fails++;
                $display("FAIL %s: actual state=%0d arm/irq/stop/rst/clr=%b expected state=%0d %b",
                         it.tag, act[7:5], act[4:0], it.v[7:5], it.v[4:0]);
            end
        end
    end

    // Driver: apply inputs for this cycle, queue the outputs expected in it.
    task automatic tick(input logic we, input logic wd, input logic rx,
                        input logic [2:0] st, input logic arm, input string tag);
        @(posedge clk);
        #1;
        sw_we    = we;
        sw_wdata = wd;
        link_rx  = rx;
        exp_q.push_back('{ev(st, arm), tag});
    endtask

    task automatic do_arm();
        tick(1'b1, 1'b1, 1'b0, 3'd0, 1'b0, "R2");
        tick(1'b0, 1'b0, 1'b0, 3'd0, 1'b1, "R2");
        tick(1'b0, 1'b0, 1'b0, 3'd1, 1'b1, "R2");
    endtask

    // Starts with the block armed; runs a full timeout and recovery.
    task automatic time_out(input int n, input int m, input bit drop_last, input bit rec_we);
        tick(1'b0, 1'b0, 1'b1, 3'd1, 1'b1, "R3");
        for (int i = 0; i < n; i++) begin
            tick(1'b0, 1'b0, (drop_last && (i == n - 1)) ? 1'b0 : 1'b1, 3'd2, 1'b1,
                 (drop_last && (i == n - 1)) ? "R5" : "R4");
        end
        tick(rec_we, 1'b1, 1'b0, 3'd3, 1'b0, "R7");
        for (int i = 0; i < m; i++) tick(rec_we, 1'b1, 1'b0, 3'd4, 1'b0, "R8");
        tick(rec_we, 1'b1, 1'b0, 3'd5, 1'b0, "R9");
        tick(rec_we, 1'b1, 1'b0, 3'd5, 1'b0, "R9");
        tick(rec_we, 1'b1, 1'b0, 3'd6, 1'b0, "R10");
        tick(1'b0, 1'b0, 1'b0, 3'd0, 1'b0, "R10");
        tick(1'b0, 1'b0, 1'b0, 3'd0, 1'b0, "R11");
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1: reset state
        tick(1'b0, 1'b0, 1'b0, 3'd0, 1'b0, "R1");
        tick(1'b0, 1'b0, 1'b1, 3'd0, 1'b0, "R1");

        // Basic timeout: N=3, M=2
        limit_rx = 16'd3; limit_stop = 16'd2;
        do_arm();
        tick(1'b0, 1'b0, 1'b0, 3'd1, 1'b1, "R3");
        time_out(3, 2, 1'b0, 1'b0);

        // R4/R8: zero limits behave as one cycle
        limit_rx = 16'd0; limit_stop = 16'd0;
        do_arm();
        time_out(1, 1, 1'b0, 1'b0);

        // R5: abandon then full restart; drop on final cycle; R11 writes locked
        limit_rx = 16'd5; limit_stop = 16'd3;
        do_arm();
        tick(1'b0, 1'b0, 1'b1, 3'd1, 1'b1, "R3");
        tick(1'b0, 1'b0, 1'b1, 3'd2, 1'b1, "R5");
        tick(1'b0, 1'b0, 1'b1, 3'd2, 1'b1, "R5");
        tick(1'b0, 1'b0, 1'b0, 3'd2, 1'b1, "R5");
        tick(1'b0, 1'b0, 1'b0, 3'd1, 1'b1, "R5");
        time_out(5, 3, 1'b1, 1'b1);

        // R6: disarm from armed
        do_arm();
        tick(1'b1, 1'b0, 1'b0, 3'd1, 1'b1, "R6");
        tick(1'b0, 1'b0, 1'b0, 3'd1, 1'b0, "R6");
        tick(1'b0, 1'b0, 1'b0, 3'd0, 1'b0, "R6");

        // R6: disarm while timing, no interrupt
        do_arm();
        tick(1'b0, 1'b0, 1'b1, 3'd1, 1'b1, "R6");
        tick(1'b1, 1'b0, 1'b1, 3'd2, 1'b1, "R6");
        tick(1'b0, 1'b0, 1'b1, 3'd2, 1'b0, "R6");
        tick(1'b0, 1'b0, 1'b1, 3'd0, 1'b0, "R6");
        tick(1'b0, 1'b0, 1'b1, 3'd0, 1'b0, "R6");
        tick(1'b0, 1'b0, 1'b0, 3'd0, 1'b0, "R6");

        wait (exp_q.size() == 0);
        #3;
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #(4 * 20000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule